// File: doc/BRIEF.md
# Run-Time Override Register

This block wraps a design storage element, from one flip-flop to a multi-bit register, so that a debug controller can change its contents while the design runs, with no rebuild. In normal operation the register captures its D input on every rising clock edge and honours the design's synchronous reset. A separate debug command port beside that path carries a strobe, a two-bit opcode, a value word and a per-bit mask. It can deposit a value once, pin bits to a fixed value, or hand pinned bits back to their natural next-state input.

The design's functional logic stays as it is. The debug path only picks which next value each bit takes. Q always shows the effective contents. A per-bit status word shows which bits are pinned. An asynchronous reset returns both the contents and the pin state to zero.

Top module: `dbg_override_reg`

## Requirements
- R1: A set command (opcode 2'b01) loads `dbg_value` into the masked bits of an unpinned register at the next edge. On the edge after that those bits capture `d` again.
- R2: A force command (opcode 2'b10) loads `dbg_value` into the masked bits at the next edge and sets their bits in `forced`.
- R3: While a bit is pinned and no command addresses it, it keeps its value on every edge, whatever `d` does.
- R4: A release command (opcode 2'b11) clears the masked bits of `forced`. On that same edge those bits capture `d`, or 0 when `srst` is high.
- R5: Commands act only when `dbg_valid` is high. With `dbg_valid` low, or with opcode 2'b00, `q` and `forced` behave exactly as they would with no command.
- R6: An unpinned bit that no command addresses captures `d` on each edge while `srst` is low.
- R7: When `srst` is high, unpinned unaddressed bits go to 0 at the edge. Pinned bits keep their value.
- R8: A set command on a pinned bit replaces its pinned value and leaves the bit pinned.
- R9: When `rst_n` goes low, `q` and `forced` go to 0 at once, without waiting for a clock edge.
- R10: A command has no effect on bits whose `dbg_mask` bit is 0.
- R11: Bit i of `forced` is 1 exactly while bit i of the register is pinned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears contents and pin state |
| srst | input | 1 | Design synchronous reset, active high |
| d | input | WIDTH | Natural next-state value |
| q | output | WIDTH | Effective register contents |
| dbg_valid | input | 1 | Debug command strobe |
| dbg_op | input | 2 | Debug opcode: 00 none, 01 set, 10 force, 11 release |
| dbg_value | input | WIDTH | Value for set and force |
| dbg_mask | input | WIDTH | Bits that the command applies to |
| forced | output | WIDTH | Per-bit pinned status |

## Verification
The hardest state to reach is a mixed word in which pinned and unpinned bits sit side by side while `d` and `srst` both move. In that state, a wrong priority between the pin, the synchronous reset and the command decode shows up only in some bit positions. The stimulus pins the upper nibble, then drives `d` to all ones and raises `srst`, and checks the upper and lower halves separately. It then re-deposits into the pinned bits and releases a two-bit subset, so that the word holds three kinds of bits at once.

// File: rtl/dbg_override_pkg.sv
package dbg_override_pkg;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SET     = 2'b01,
        OP_FORCE   = 2'b10,
        OP_RELEASE = 2'b11
    } dbg_op_e;

    typedef struct packed {
        logic store;
        logic pinned;
    } cell_state_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_override_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             valid,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] set_v,
    output logic [WIDTH-1:0] force_v,
    output logic [WIDTH-1:0] rel_v
);
    dbg_op_e op_e;

    always_comb begin
        op_e    = dbg_op_e'(op);
        set_v   = '0;
        force_v = '0;
        rel_v   = '0;
        if (valid) begin
            unique case (op_e)
                OP_SET:     set_v   = mask;
                OP_FORCE:   force_v = mask;
                OP_RELEASE: rel_v   = mask;
                default:    ;
            endcase
        end
    end

    always_comb begin
        assert_decode_exclusive_R5: assert ((set_v & force_v) == '0 && (set_v & rel_v) == '0
                                            && (force_v & rel_v) == '0)
            else $error("decoded actions overlap");
    end
endmodule

// File: rtl/dbg_bit_cell.sv
module dbg_bit_cell
    import dbg_override_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic d,
    input  logic set_en,
    input  logic force_en,
    input  logic rel_en,
    input  logic val,
    output logic q,
    output logic pinned
);
    cell_state_t st_d, st_q;
    logic        hit;

    assign hit = set_en | force_en | rel_en;

    always_comb begin
        st_d = st_q;
        if (force_en) begin
            st_d.store  = val;
            st_d.pinned = 1'b1;
        end else if (set_en) begin
            st_d.store  = val;
        end else if (rel_en) begin
            st_d.pinned = 1'b0;
            st_d.store  = srst ? 1'b0 : d;
        end else if (!st_q.pinned) begin
            st_d.store  = srst ? 1'b0 : d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q      = st_q.store;
    assign pinned = st_q.pinned;

    assert_set_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (q == $past(val)));
    assert_force_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        force_en |=> (q == $past(val)) && pinned);
    assert_pin_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pinned && !hit) |=> (q == $past(q)) && pinned);
    assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |=> !pinned && (q == ($past(srst) ? 1'b0 : $past(d))));
    assert_natural_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pinned && !hit && !srst) |=> (q == $past(d)));
    assert_sync_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pinned && !hit && srst) |=> (q == 1'b0));
    assert_set_keeps_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && pinned) |=> pinned);
endmodule

// File: rtl/dbg_override_reg.sv
module dbg_override_reg
    import dbg_override_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    input  logic             dbg_valid,
    input  logic [1:0]       dbg_op,
    input  logic [WIDTH-1:0] dbg_value,
    input  logic [WIDTH-1:0] dbg_mask,
    output logic [WIDTH-1:0] forced
);
    logic [WIDTH-1:0] set_v, force_v, rel_v;

    dbg_cmd_decode #(.WIDTH(WIDTH)) u_decode (
        .valid   (dbg_valid),
        .op      (dbg_op),
        .mask    (dbg_mask),
        .set_v   (set_v),
        .force_v (force_v),
        .rel_v   (rel_v)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        dbg_bit_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .srst     (srst),
            .d        (d[i]),
            .set_en   (set_v[i]),
            .force_en (force_v[i]),
            .rel_en   (rel_v[i]),
            .val      (dbg_value[i]),
            .q        (q[i]),
            .pinned   (forced[i])
        );
    end

    assert_idle_keeps_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_valid || dbg_op == 2'b00) |=> (forced == $past(forced)));
    assert_unmasked_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid |=> ((forced & ~$past(dbg_mask)) == ($past(forced) & ~$past(dbg_mask))));
endmodule

// File: tb/dbg_override_reg_test.sv
`timescale 1ns/1ps
module dbg_override_reg_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         srst = 1'b0;
    logic [W-1:0] d = '0;
    logic [W-1:0] q;
    logic         dbg_valid = 1'b0;
    logic [1:0]   dbg_op = 2'b00;
    logic [W-1:0] dbg_value = '0;
    logic [W-1:0] dbg_mask = '0;
    logic [W-1:0] forced;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_override_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .srst(srst), .d(d), .q(q),
        .dbg_valid(dbg_valid), .dbg_op(dbg_op), .dbg_value(dbg_value),
        .dbg_mask(dbg_mask), .forced(forced)
    );

    task automatic check(input string req, input logic [W-1:0] exp_q, input logic [W-1:0] exp_f);
        checks++;
        if (q !== exp_q || forced !== exp_f) begin
            errors++;
            $display("FAIL %s: q=%h forced=%h expected q=%h forced=%h", req, q, forced, exp_q, exp_f);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [W-1:0] val, input logic [W-1:0] m);
        dbg_valid = 1'b1; dbg_op = op; dbg_value = val; dbg_mask = m;
    endtask

    task automatic idle();
        dbg_valid = 1'b0; dbg_op = 2'b00; dbg_value = '0; dbg_mask = '0;
    endtask

    task automatic t_reset();
        #1; check("R9 reset state", 8'h00, 8'h00);
        step(); rst_n = 1'b1; step();
    endtask

    task automatic t_natural();
        d = 8'hA5; step(); check("R6 capture", 8'hA5, 8'h00);
        d = 8'h3C; step(); check("R6 capture", 8'h3C, 8'h00);
        srst = 1'b1; step(); check("R7 sync reset unpinned", 8'h00, 8'h00);
        srst = 1'b0;
    endtask

    task automatic t_set();
        d = 8'h0F; cmd(2'b01, 8'hF0, 8'hFF); step();
        check("R1 set deposit", 8'hF0, 8'h00);
        idle(); step(); check("R1 back to d", 8'h0F, 8'h00);
        d = 8'h00; cmd(2'b01, 8'hFF, 8'h0F); step();
        check("R10 masked set", 8'h0F, 8'h00);
        idle(); step();
    endtask

    task automatic t_force();
        d = 8'h00; cmd(2'b10, 8'hAA, 8'hF0); step();
        check("R2 R11 force", 8'hA0, 8'hF0);
        idle(); d = 8'hFF; step(); check("R3 pinned holds", 8'hAF, 8'hF0);
        srst = 1'b1; step(); check("R7 pin beats sync reset", 8'hA0, 8'hF0);
        srst = 1'b0;
    endtask

    task automatic t_set_pinned();
        d = 8'hFF; cmd(2'b01, 8'h50, 8'hF0); step();
        check("R8 set on pinned", 8'h5F, 8'hF0);
        idle(); step(); check("R8 pin kept", 8'h5F, 8'hF0);
    endtask

    task automatic t_ignore();
        d = 8'h33; cmd(2'b10, 8'h00, 8'hFF); dbg_valid = 1'b0; step();
        check("R5 strobe low ignored", 8'h53, 8'hF0);
        cmd(2'b00, 8'h00, 8'hFF); d = 8'h11; step();
        check("R5 opcode none", 8'h51, 8'hF0);
        idle();
    endtask

    task automatic t_release();
        d = 8'hFF; cmd(2'b11, 8'h00, 8'h30); step();
        check("R4 R10 partial release", 8'h7F, 8'hC0);
        d = 8'h00; cmd(2'b11, 8'h00, 8'hFF); step();
        check("R4 full release", 8'h00, 8'h00);
        idle(); d = 8'h96; step(); check("R4 R6 free again", 8'h96, 8'h00);
    endtask

    task automatic t_async();
        cmd(2'b10, 8'hFF, 8'hFF); step(); idle();
        check("R2 force all", 8'hFF, 8'hFF);
        #0.5 rst_n = 1'b0; #0.5;
        check("R9 async clear", 8'h00, 8'h00);
        step(); rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_natural();
        t_set();
        t_force();
        t_set_pinned();
        t_ignore();
        t_release();
        t_async();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule